// File: doc/BRIEF.md
# Anchor-Relative Operation Start Controller

This block hands out start enables to a fixed set of datapath operations. The start time of each operation is not a fixed cycle number. Each operation names a set of anchors, which are events of data-dependent duration, and gives a cycle offset after each of them. The operation starts in the first cycle in which every one of its anchors has completed and its offset has elapsed. One anchor is the source: it completes on its own right after the run starts. The other anchors complete when their completion strobe input is seen, for example at the end of an external handshake.

Each anchor owns one offset tracker, and each operation owns a small piece of synchronization logic that combines the trackers it depends on. A parameter picks how the trackers are built. The first choice is a saturating binary counter per anchor, with a comparator per anchor dependency. The second is a thermometer-filling shift register per anchor, with a plain AND of fixed taps. Both choices give the same enable sequence, cycle for cycle. When an anchor takes longer, the schedule stretches at run time and the logic does not change. The last operation is the sink. A done flag reports that the sink has started.

Top module: `sched_act_ctrl`

## Requirements
- R1: After reset all `op_en_o` bits and `done_o` are 0. Completion strobes seen before the first start pulse have no effect.
- R2: A start pulse sampled at clock edge E makes the source anchor (anchor 0) complete in the cycle right after E, which is run cycle 0. An operation whose only anchor is the source, with offset d, pulses its enable in run cycle d. With the default parameters, operation 0 uses source offset 2.
- R3: `anch_done_i` bit k is the completion strobe of anchor k+1. If it is sampled high at the edge that starts run cycle s, that anchor's completion is in run cycle s. An operation with that anchor and offset d pulses in run cycle s+d. With the default parameters, operation 1 uses anchor 1 with offset 0.
- R4: An operation with several anchors pulses in the run cycle equal to the largest of (completion cycle + offset) over its anchors. With the default parameters, operation 2 uses source+5 and anchor 1+1, and operation 3 (the sink) uses anchor 1+3 and anchor 2+2.
- R5: Each enable is high for exactly one cycle per run and is not asserted again until the next start pulse.
- R6: Only the first completion strobe of an anchor in a run counts. Later strobes of that anchor in the same run, and strobes sampled at the same edge as a start pulse, have no effect.
- R7: An anchor that completed long ago (more than the largest offset) never wraps. Its dependent operations still start at the right cycle and never fire a second time.
- R8: `done_o` rises in the cycle after the sink enable pulse and stays high until the next start pulse.
- R9: A start pulse during a run abandons that run. The new run's timing counts only from the new start, and done, fired state and trackers are cleared.
- R10: The counter build (`USE_SHIFT`=0) and the shift-register build (`USE_SHIFT`=1) produce identical `op_en_o` and `done_o` sequences for the same inputs.
- R11: An operation does not start while any anchor in its set has not yet completed, however long that anchor takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; begins (or restarts) a run |
| anch_done_i | input | NUM_ANCH-1 | Completion strobes; bit k belongs to anchor k+1 |
| op_en_o | output | NUM_OPS | One-cycle start enable per operation |
| done_o | output | 1 | Sink operation has started in this run |

## Verification
A tracker that is wrong, such as a counter that wraps, a shift stage that drops its bit, or a completion captured twice, shows up at the enable ports. An enable then appears one or more cycles early or late, or a second time in the same run. This is visible in the same cycle the dependent operation should have started. A fired bit that is wrong shows up as a repeated enable in the very next cycle. A bad done register differs from the sink enable one cycle later. Running both tracker builds side by side exposes any disagreement between them in the first cycle where their enables differ.

// File: rtl/sched_act_pkg.sv
package sched_act_pkg;

  // Width of a saturating elapsed-cycle counter that must reach max_ofs+1.
  function automatic int cnt_width(int max_ofs);
    return $clog2(max_ofs + 2);
  endfunction

  // Width of one offset field in the schedule parameter.
  function automatic int ofs_width(int max_ofs);
    return $clog2(max_ofs + 1);
  endfunction

  // Width of the tracker bus from one anchor to the operation logic.
  function automatic int trk_width(bit use_shift, int max_ofs);
    return use_shift ? (max_ofs + 1) : (cnt_width(max_ofs) + 1);
  endfunction

endpackage

// File: rtl/act_anchor_trk.sv
module act_anchor_trk
  import sched_act_pkg::*;
#(
  parameter bit USE_SHIFT = 1'b0,
  parameter int MAX_OFS   = 7,
  parameter bit IS_SRC    = 1'b0,
  parameter int TW        = trk_width(USE_SHIFT, MAX_OFS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          arm_i,
  input  logic          strobe_i,
  output logic [TW-1:0] trk_o
);

  localparam int CW = cnt_width(MAX_OFS);

  // Completion event, visible for one cycle; then remembered in got_q.
  logic cmpl_q;
  logic got_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmpl_q <= 1'b0;
      got_q  <= 1'b0;
    end else if (clr_i) begin
      cmpl_q <= IS_SRC;
      got_q  <= 1'b0;
    end else begin
      cmpl_q <= arm_i & strobe_i & ~(got_q | cmpl_q);
      got_q  <= got_q | cmpl_q;
    end
  end

  AST_CMPL_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_q && !clr_i |=> !cmpl_q); // R6

  generate
    if (USE_SHIFT) begin : g_shr
      // Thermometer shift register: stage k set => elapsed >= k+1.
      logic [MAX_OFS-1:0] sr_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sr_q <= '0;
        end else if (clr_i) begin
          sr_q <= '0;
        end else begin
          sr_q[0] <= sr_q[0] | cmpl_q;
          for (int k = 1; k < MAX_OFS; k++) begin
            sr_q[k] <= sr_q[k] | sr_q[k-1];
          end
        end
      end

      assign trk_o = {sr_q, cmpl_q | got_q};

      AST_SHR_NO_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sr_q[MAX_OFS-1] && !clr_i |=> sr_q[MAX_OFS-1]); // R7
    end else begin : g_cnt
      // Saturating elapsed counter: 0 in the completion cycle.
      localparam logic [CW-1:0] SAT = CW'(MAX_OFS + 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (clr_i) begin
          cnt_q <= '0;
        end else if ((cmpl_q | got_q) && (cnt_q != SAT)) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign trk_o = {cmpl_q | got_q, cnt_q};

      AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q != '0) && !clr_i |=> (cnt_q >= $past(cnt_q))); // R7
    end
  endgenerate

endmodule

// File: rtl/act_op_sync.sv
module act_op_sync
  import sched_act_pkg::*;
#(
  parameter int                       NUM_ANCH  = 3,
  parameter bit                       USE_SHIFT = 1'b0,
  parameter int                       MAX_OFS   = 7,
  parameter int                       TW        = trk_width(USE_SHIFT, MAX_OFS),
  parameter int                       OW        = ofs_width(MAX_OFS),
  parameter logic [NUM_ANCH-1:0]      MASK      = '1,
  parameter logic [NUM_ANCH*OW-1:0]   OFS       = '0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         arm_i,
  input  logic [NUM_ANCH-1:0][TW-1:0]  trk_i,
  output logic                         en_o
);

  localparam int CW = cnt_width(MAX_OFS);

  // One anchor's condition: comparator (counter build) or tap select (shift build).
  function automatic logic anchor_ok(logic [TW-1:0] v, logic [OW-1:0] ofs);
    logic r;
    r = 1'b0;
    if (USE_SHIFT) begin
      for (int k = 0; k < TW; k++) begin
        if (k == int'(ofs)) r = v[k];
      end
    end else begin
      r = v[TW-1] && (v[CW-1:0] >= CW'(ofs));
    end
    return r;
  endfunction

  logic hit;
  logic fired_q;

  always_comb begin
    hit = |MASK;
    for (int a = 0; a < NUM_ANCH; a++) begin
      if (MASK[a]) hit = hit & anchor_ok(trk_i[a], OFS[a*OW +: OW]);
    end
  end

  assign en_o = arm_i & ~fired_q & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q <= 1'b0;
    end else if (clr_i) begin
      fired_q <= 1'b0;
    end else begin
      fired_q <= fired_q | en_o;
    end
  end

  AST_EN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o && !clr_i |=> !en_o); // R5

endmodule

// File: rtl/sched_act_ctrl.sv
module sched_act_ctrl
  import sched_act_pkg::*;
#(
  parameter int NUM_ANCH  = 3,
  parameter int NUM_OPS   = 4,
  parameter int MAX_OFS   = 7,
  parameter bit USE_SHIFT = 1'b0,
  // Anchor set of operation o at bits [o*NUM_ANCH +: NUM_ANCH].
  parameter logic [NUM_OPS*NUM_ANCH-1:0] OP_MASK = 12'b110_011_010_001,
  // Offset of operation o after anchor a at field (o*NUM_ANCH + a).
  parameter logic [NUM_OPS*NUM_ANCH*ofs_width(MAX_OFS)-1:0] OP_OFS =
    {3'd2, 3'd3, 3'd0,  3'd0, 3'd1, 3'd5,  3'd0, 3'd0, 3'd0,  3'd0, 3'd0, 3'd2}
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [NUM_ANCH-2:0] anch_done_i,
  output logic [NUM_OPS-1:0]  op_en_o,
  output logic                done_o
);

  localparam int OW   = ofs_width(MAX_OFS);
  localparam int TW   = trk_width(USE_SHIFT, MAX_OFS);
  localparam int SINK = NUM_OPS - 1;

  logic                        run_q;
  logic                        done_q;
  logic [NUM_ANCH-1:0][TW-1:0] trk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= done_q | op_en_o[SINK];
    end
  end

  assign done_o = done_q;

  generate
    for (genvar a = 0; a < NUM_ANCH; a++) begin : g_anch
      logic strobe;
      if (a == 0) begin : g_src
        assign strobe = 1'b0;
      end else begin : g_ext
        assign strobe = anch_done_i[a-1];
      end

      act_anchor_trk #(
        .USE_SHIFT (USE_SHIFT),
        .MAX_OFS   (MAX_OFS),
        .IS_SRC    (a == 0),
        .TW        (TW)
      ) i_trk (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (start_i),
        .arm_i    (run_q),
        .strobe_i (strobe),
        .trk_o    (trk[a])
      );
    end

    for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
      act_op_sync #(
        .NUM_ANCH  (NUM_ANCH),
        .USE_SHIFT (USE_SHIFT),
        .MAX_OFS   (MAX_OFS),
        .TW        (TW),
        .OW        (OW),
        .MASK      (OP_MASK[o*NUM_ANCH +: NUM_ANCH]),
        .OFS       (OP_OFS[o*NUM_ANCH*OW +: NUM_ANCH*OW])
      ) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (start_i),
        .arm_i  (run_q),
        .trk_i  (trk),
        .en_o   (op_en_o[o])
      );
    end
  endgenerate

  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(op_en_o[SINK])); // R8

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o); // R8

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o); // R9

endmodule

// File: tb/test_sched_act_ctrl.sv
module test_sched_act_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] strobe = 2'b00;
  logic [3:0] en_c, en_s;
  logic       done_c, done_s;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sched_act_ctrl #(.USE_SHIFT(1'b0)) i_sched_act_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .anch_done_i(strobe),
    .op_en_o(en_c), .done_o(done_c));

  sched_act_ctrl #(.USE_SHIFT(1'b1)) i_sched_act_ctrl_shr (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .anch_done_i(strobe),
    .op_en_o(en_s), .done_o(done_s));

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Expected start cycle of each operation for completion cycles s1, s2.
  function automatic int exp_cycle(int o, int s1, int s2);
    case (o)
      0: return 2;                          // R2
      1: return s1;                         // R3
      2: return imax(5, s1 + 1);            // R4
      default: return imax(s1 + 3, s2 + 2); // R4
    endcase
  endfunction

  // One run; checks cycles 0..len. dupN: repeated strobe cycle (0 = none).
  task automatic run(input int s1, input int s2, input int dup1, input int dup2,
                     input bit glitch, input int len, input string tag);
    int e[4];
    for (int o = 0; o < 4; o++) e[o] = exp_cycle(o, s1, s2);
    @(negedge clk);
    start  = 1'b1;
    strobe = glitch ? 2'b11 : 2'b00;
    @(posedge clk);
    for (int r = 0; r <= len; r++) begin
      @(negedge clk);
      start = 1'b0;
      for (int o = 0; o < 4; o++) begin
        string req;
        req = (r == e[o]) ? ((o == 0) ? "R2" : (o == 1) ? "R3" : "R4") : "R5";
        chk(en_c[o], r == e[o], {req, " ", tag}, $sformatf("cnt op%0d cycle %0d", o, r));
        chk(en_s[o], r == e[o], {req, " ", tag}, $sformatf("shr op%0d cycle %0d", o, r));
      end
      chk(done_c, r > e[3], {"R8 ", tag}, $sformatf("cnt done cycle %0d", r));
      chk(done_s, r > e[3], {"R8 ", tag}, $sformatf("shr done cycle %0d", r));
      chk(en_c == en_s && done_c == done_s, 1'b1, "R10", $sformatf("builds differ cycle %0d", r));
      strobe[0] = (r + 1 == s1) || (r + 1 == dup1);
      strobe[1] = (r + 1 == s2) || (r + 1 == dup2);
      @(posedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, and strobes before any start are ignored.
    chk(|en_c | |en_s, 1'b0, "R1", "enables after reset");
    chk(done_c | done_s, 1'b0, "R1", "done after reset");
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      strobe = k[1:0];
      chk(|en_c | |en_s | done_c | done_s, 1'b0, "R1", $sformatf("idle strobe %0d", k));
    end
    @(negedge clk);
    strobe = 2'b00;

    // Near-exhaustive sweep of completion cycles (R3, R4, R11 when late).
    for (int s1 = 1; s1 <= 6; s1++) begin
      for (int s2 = 1; s2 <= 12; s2++) begin
        run(s1, s2, 0, 0, 1'b0, imax(s1 + 3, s2 + 2) + 3, "sweep R11");
      end
    end

    // R6: repeated strobes and strobes coinciding with start are ignored.
    run(2, 4, 3, 6, 1'b0, 12, "dup R6");
    run(3, 3, 7, 5, 1'b1, 12, "glitch R6");

    // R7: long waits well beyond the largest offset.
    run(20, 45, 30, 50, 1'b0, 60, "long R7");

    // R9: restart mid-run, then a clean run.
    run(2, 9, 0, 0, 1'b0, 3, "cut R9");
    run(1, 1, 0, 0, 1'b0, 8, "restart R9");
    run(4, 2, 0, 0, 1'b0, 10, "after R9");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule